// File: doc/BRIEF.md
# Two-Channel Reloading PWM Timer

This block is a register-mapped timer with two counter channels. Each channel holds a reload value, a live counter and a control word. Software writes the reload values, can force a reload value straight into a stopped counter, and can start both channels on the same clock edge. When both channels are set up for waveform generation, channel 0 sets the length of the waveform period and channel 1 sets how long the output stays high at the start of each period.

Each counter steps up or down, as its control word selects. When a counter passes its terminal count it wraps, and on the next clock it reloads. A reload value L therefore gives a cycle of L + 2 clocks when counting down, and MAX − L + 2 clocks when counting up, where MAX is the all-ones value of the counter width. A new reload value written while the waveform runs is picked up only at the next reload, so the period in progress is never cut short. The single output is active high. It is held low whenever the channels are not in waveform mode. It also stays low for any period whose high time is not shorter than the period itself.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset every register reads 0 and `pwm_o` is low.
- R2: With both channels counting down, reload values L0 and L1 and L1 + 2 < L0 + 2, `pwm_o` repeats with a period of L0 + 2 clocks and is high for the first L1 + 2 clocks of each period.
- R3: With both channels counting up, the period is MAX − L0 + 2 clocks and the high time is MAX − L1 + 2 clocks (MAX = 2^CNT_W − 1).
- R4: A reload-value write made while the waveform runs leaves the period in progress and its high time unchanged; the new values apply from the next period on.
- R5: The waveform runs only when both control words have bits gen(2), pwm(3), run(4) and autoreload(5) set and bits capture(1) and load(6) clear, and channel 0 also has chain(7) clear; otherwise `pwm_o` stays low.
- R6: If the high-time cycle count is equal to or greater than the period cycle count, `pwm_o` stays low for the whole period.
- R7: A write that clears the run bit of channel 0 drives `pwm_o` low from the clock edge of that write onward.
- R8: Writing a control word with load (bit 6) set copies the channel's reload value into its counter on the next clock, and the load bit then reads 0.
- R9: Counter registers are read-only and return the live count; writes to them have no effect and unmapped offsets read 0.
- R10: Writing a control word with start-all (bit 8) set sets the run bit of both channels on the same edge; bit 8 always reads 0, and the two counters then step in lockstep.
- R11: Register map, byte offsets: 0x00 control 0, 0x04 reload 0, 0x08 control 1, 0x0C reload 1, 0x10 counter 0, 0x14 counter 1; reload registers keep only the low CNT_W bits; control bit 0 selects down counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_o | output | 1 | Active-high PWM output |

## Verification
The bench measures the output's high time and period in both count directions and compares them with the offset-by-two formulas. A design that dropped the wrap cycle, or that started counting on the enable edge itself, would be one clock short. The bench rewrites both reload values in the middle of a high phase. A design that reloaded at once would shorten that period instead of finishing it with the old timing. It also tries equal and longer high times, a cascade or capture bit set, and stopping the waveform in mid-period. A design that let the high time win would hold the output high, and one that registered only the stop would leave the output high for an extra clock.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;
    localparam int CTL_W  = 8;
    localparam int ALL_BIT = 8;   // write-only start-all strobe

    // Control word, bit 7 down to bit 0
    typedef struct packed {
        logic chain;    // 7
        logic load;     // 6
        logic arl;      // 5 auto reload
        logic run;      // 4
        logic pwm;      // 3
        logic gen;      // 2 generate output enable
        logic capt;     // 1 capture mode
        logic down;     // 0 count direction
    } ctl_t;

    typedef enum logic [2:0] {
        IDX_CTL0  = 3'd0,
        IDX_LOAD0 = 3'd1,
        IDX_CTL1  = 3'd2,
        IDX_LOAD1 = 3'd3,
        IDX_CNT0  = 3'd4,
        IDX_CNT1  = 3'd5
    } reg_idx_e;

    // Clocks in one counting cycle for a given reload value
    function automatic logic [REG_W+1:0] cyc_count(input logic down,
                                                   input logic [REG_W-1:0] ld,
                                                   input logic [REG_W-1:0] maxv);
        if (down)
            return (REG_W+2)'(ld) + (REG_W+2)'(2);
        return (REG_W+2)'(maxv) - (REG_W+2)'(ld) + (REG_W+2)'(2);
    endfunction

    // Channel set up for waveform generation (chain checked separately)
    function automatic logic wave_ready(input ctl_t c);
        return c.gen && c.pwm && c.run && c.arl && !c.capt && !c.load;
    endfunction

endpackage

// File: rtl/dpt_regs.sv
module dpt_regs
    import dpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic [CNT_W-1:0]    cnt_i   [2],
    output ctl_t                ctl_o   [2],
    output logic [CNT_W-1:0]    load_o  [2],
    output logic [REG_W-1:0]    rdata
);

    reg_idx_e idx;
    logic     start_all;
    logic     wr_ctl  [2];
    logic     wr_load [2];
    logic     unused_bits;

    assign idx         = reg_idx_e'(addr[ADDR_W-1:2]);
    assign start_all   = we && wdata[ALL_BIT] && (idx == IDX_CTL0 || idx == IDX_CTL1);
    assign wr_ctl[0]   = we && (idx == IDX_CTL0);
    assign wr_ctl[1]   = we && (idx == IDX_CTL1);
    assign wr_load[0]  = we && (idx == IDX_LOAD0);
    assign wr_load[1]  = we && (idx == IDX_LOAD1);
    assign unused_bits = ^{addr[1:0], wdata[REG_W-1:ALL_BIT+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                ctl_o[k]  <= '0;
                load_o[k] <= '0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (ctl_o[k].load)
                    ctl_o[k].load <= 1'b0;
                if (start_all)
                    ctl_o[k].run <= 1'b1;
                if (wr_ctl[k]) begin
                    ctl_o[k] <= ctl_t'(wdata[CTL_W-1:0]);
                    if (start_all)
                        ctl_o[k].run <= 1'b1;
                end
                if (wr_load[k])
                    load_o[k] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        case (idx)
            IDX_CTL0:  rdata = REG_W'(ctl_o[0]);
            IDX_LOAD0: rdata = REG_W'(load_o[0]);
            IDX_CTL1:  rdata = REG_W'(ctl_o[1]);
            IDX_LOAD1: rdata = REG_W'(load_o[1]);
            IDX_CNT0:  rdata = REG_W'(cnt_i[0]);
            IDX_CNT1:  rdata = REG_W'(cnt_i[1]);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dpt_chan.sv
module dpt_chan
    import dpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              resync,
    output logic [CNT_W-1:0]  cnt,
    output logic              reload_evt,
    output logic              term_evt
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    logic run_q;
    logic tc_q;
    logic active;
    logic at_term;
    logic unused_ctl;

    assign active     = ctl.run && run_q;
    assign at_term    = ctl.down ? (cnt == '0) : (cnt == MAXV);
    assign reload_evt = active && ((tc_q && ctl.arl) || resync);
    assign term_evt   = active && tc_q;
    assign unused_ctl = ^{ctl.chain, ctl.pwm, ctl.gen, ctl.capt};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            tc_q  <= 1'b0;
            run_q <= 1'b0;
        end else begin
            run_q <= ctl.run;
            if (ctl.load) begin
                cnt  <= load_val;
                tc_q <= 1'b0;
            end else if (active) begin
                if (reload_evt) begin
                    cnt  <= load_val;
                    tc_q <= 1'b0;
                end else begin
                    cnt  <= ctl.down ? cnt - 1'b1 : cnt + 1'b1;
                    tc_q <= at_term;
                end
            end
        end
    end

endmodule

// File: rtl/dpt_pwm_out.sv
module dpt_pwm_out
    import dpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl0,
    input  ctl_t              ctl1,
    input  logic [CNT_W-1:0]  load0,
    input  logic [CNT_W-1:0]  load1,
    input  logic              period_evt,
    input  logic              duty_evt,
    output logic              pwm_act,
    output logic              pwm_o
);

    localparam logic [CNT_W-1:0] MAXV   = '1;
    localparam logic [REG_W-1:0] MAXV32 = REG_W'(MAXV);

    logic             act_q;
    logic             pwm_q;
    logic             start;
    logic             high_ok;
    logic [REG_W+1:0] cyc_per;
    logic [REG_W+1:0] cyc_hi;
    logic             unused_chain;

    assign pwm_act      = wave_ready(ctl0) && !ctl0.chain && wave_ready(ctl1);
    assign start        = pwm_act && !act_q;
    assign cyc_per      = cyc_count(ctl0.down, REG_W'(load0), MAXV32);
    assign cyc_hi       = cyc_count(ctl1.down, REG_W'(load1), MAXV32);
    assign high_ok      = cyc_hi < cyc_per;
    assign pwm_o        = pwm_q && pwm_act;
    assign unused_chain = ctl1.chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            pwm_q <= 1'b0;
        end else begin
            act_q <= pwm_act;
            if (!pwm_act)
                pwm_q <= 1'b0;
            else if (start || period_evt)
                pwm_q <= high_ok;
            else if (duty_evt)
                pwm_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
    import dpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [4:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                pwm_o
);

    ctl_t             ctl    [2];
    logic [CNT_W-1:0] ld     [2];
    logic [CNT_W-1:0] cnt    [2];
    logic             rl_evt [2];
    logic             tm_evt [2];
    logic             rs     [2];
    logic             act;

    // Named views used by the bound checker
    ctl_t             ctl0_s;
    ctl_t             ctl1_s;
    logic [31:0]      cnt0_x;
    logic [31:0]      load0_x;

    assign ctl0_s  = ctl[0];
    assign ctl1_s  = ctl[1];
    assign cnt0_x  = 32'(cnt[0]);
    assign load0_x = 32'(ld[0]);

    dpt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cnt_i  (cnt),
        .ctl_o  (ctl),
        .load_o (ld),
        .rdata  (bus_rdata)
    );

    for (genvar k = 0; k < 2; k++) begin : g_chan
        if (k == 0) begin : g_period
            assign rs[k] = 1'b0;
        end else begin : g_duty
            assign rs[k] = act && rl_evt[0];
        end
        dpt_chan #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .ctl        (ctl[k]),
            .load_val   (ld[k]),
            .resync     (rs[k]),
            .cnt        (cnt[k]),
            .reload_evt (rl_evt[k]),
            .term_evt   (tm_evt[k])
        );
    end

    dpt_pwm_out #(.CNT_W(CNT_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .ctl0       (ctl[0]),
        .ctl1       (ctl[1]),
        .load0      (ld[0]),
        .load1      (ld[1]),
        .period_evt (rl_evt[0]),
        .duty_evt   (tm_evt[1]),
        .pwm_act    (act),
        .pwm_o      (pwm_o)
    );

endmodule

// File: rtl/dual_pwm_timer_chk.sv
module dual_pwm_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        pwm_o,
    input logic        ctl0_run,
    input logic        ctl1_run,
    input logic        ctl0_load,
    input logic [31:0] cnt0,
    input logic [31:0] load0
);

    a_r7_stop_low: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 5'h00 && !bus_wdata[4] && !bus_wdata[8]) |=> !pwm_o);

    a_r8_load_copies: assert property (@(posedge clk) disable iff (rst)
        ctl0_load |=> (cnt0 == $past(load0)));

    a_r8_load_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl0_load && !(bus_we && bus_addr == 5'h00)) |=> !ctl0_load);

    a_r10_start_both: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == 5'h00 || bus_addr == 5'h08) && bus_wdata[8])
        |=> (ctl0_run && ctl1_run));

    a_r9_idle_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl0_run && !ctl0_load) |=> $stable(cnt0));

endmodule

bind dual_pwm_timer dual_pwm_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pwm_o     (pwm_o),
    .ctl0_run  (ctl0_s.run),
    .ctl1_run  (ctl1_s.run),
    .ctl0_load (ctl0_s.load),
    .cnt0      (cnt0_x),
    .load0     (load0_x)
);

// File: tb/dual_pwm_timer_tb.sv
`timescale 1ns/1ps
module dual_pwm_timer_tb;

    localparam logic [4:0] A_CTL0 = 5'h00, A_LD0 = 5'h04, A_CTL1 = 5'h08,
                           A_LD1 = 5'h0C, A_CNT0 = 5'h10, A_CNT1 = 5'h14;
    localparam logic [31:0] MAXV = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // pwm monitor
    int cyc = 0, rise_t = 0, nrise = 0, last_per = 0, last_hi = 0, hi_cycles = 0;
    bit rise_seen = 0;
    logic prev = 1'b0;

    always #2 clk = ~clk;

    dual_pwm_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (pwm_o) hi_cycles++;
            if (pwm_o && !prev) begin
                if (rise_seen) last_per = cyc - rise_t;
                rise_t = cyc;
                rise_seen = 1;
                nrise++;
            end
            if (!pwm_o && prev) last_hi = cyc - rise_t;
            prev = pwm_o;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_rises(input int n);
        int target;
        target = nrise + n;
        while (nrise < target) @(negedge clk);
    endtask

    task automatic stop_all();
        wr(A_CTL0, 32'h0);
        wr(A_CTL1, 32'h0);
        repeat (3) @(negedge clk);
    endtask

    // load both counters, then configure and start together
    task automatic start_wave(input logic dir, input logic [31:0] l0, input logic [31:0] l1,
                              input logic [31:0] x0, input logic [31:0] x1);
        stop_all();
        wr(A_LD0, l0);
        wr(A_LD1, l1);
        wr(A_CTL0, 32'h40 | 32'(dir));
        wr(A_CTL1, 32'h40 | 32'(dir));
        wr(A_CTL0, 32'h2C | 32'(dir) | x0);
        wr(A_CTL1, 32'h12C | 32'(dir) | x1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(5'(a * 4), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset pwm", 32'(pwm_o), 32'h0);
    endtask

    task automatic t_down();
        start_wave(1'b1, 32'd8, 32'd3, 0, 0);
        wait_rises(2);
        check("R2 down period", 32'(last_per), 32'd10);
        check("R2 down high", 32'(last_hi), 32'd5);
        wait_rises(1);
        check("R2 down period repeat", 32'(last_per), 32'd10);
        check("R2 down high repeat", 32'(last_hi), 32'd5);
    endtask

    task automatic t_up();
        start_wave(1'b0, MAXV - 32'd10, MAXV - 32'd4, 0, 0);
        wait_rises(2);
        check("R3 up period", 32'(last_per), 32'd12);
        check("R3 up high", 32'(last_hi), 32'd6);
    endtask

    task automatic t_update();
        start_wave(1'b1, 32'd8, 32'd3, 0, 0);
        wait_rises(2);
        wr(A_LD0, 32'd18);
        wr(A_LD1, 32'd5);
        wait_rises(1);
        check("R4 old period kept", 32'(last_per), 32'd10);
        check("R4 old high kept", 32'(last_hi), 32'd5);
        wait_rises(1);
        check("R4 new period", 32'(last_per), 32'd20);
        check("R4 new high", 32'(last_hi), 32'd7);
    endtask

    task automatic t_low_cases();
        start_wave(1'b1, 32'd8, 32'd8, 0, 0);
        hi_cycles = 0;
        repeat (40) @(negedge clk);
        check("R6 equal counts stay low", 32'(hi_cycles), 32'd0);
        start_wave(1'b1, 32'd8, 32'd12, 0, 0);
        hi_cycles = 0;
        repeat (40) @(negedge clk);
        check("R6 longer high stays low", 32'(hi_cycles), 32'd0);
        start_wave(1'b1, 32'd8, 32'd3, 32'h80, 0);
        hi_cycles = 0;
        repeat (40) @(negedge clk);
        check("R5 chain on channel 0 blocks output", 32'(hi_cycles), 32'd0);
        start_wave(1'b1, 32'd8, 32'd3, 0, 32'h02);
        hi_cycles = 0;
        repeat (40) @(negedge clk);
        check("R5 capture on channel 1 blocks output", 32'(hi_cycles), 32'd0);
    endtask

    task automatic t_disable();
        start_wave(1'b1, 32'd8, 32'd3, 0, 0);
        wait_rises(2);
        check("R7 high before stop", 32'(pwm_o), 32'h1);
        wr(A_CTL0, 32'h0);
        check("R7 low right after stop", 32'(pwm_o), 32'h0);
        hi_cycles = 0;
        repeat (30) @(negedge clk);
        check("R7 stays low", 32'(hi_cycles), 32'd0);
    endtask

    task automatic t_load_map();
        logic [31:0] d;
        stop_all();
        wr(A_LD0, 32'h1234);
        wr(A_CTL0, 32'h40);
        @(negedge clk);
        rd(A_CNT0, d);
        check("R8 load copies into counter", d, 32'h1234);
        rd(A_CTL0, d);
        check("R8 load bit self-clears", d, 32'h0);
        wr(A_CNT0, 32'h5555);
        rd(A_CNT0, d);
        check("R9 counter write ignored", d, 32'h1234);
        rd(5'h18, d);
        check("R9 unmapped reads zero", d, 32'h0);
        wr(A_LD1, 32'h0000ABCD);
        rd(A_LD1, d);
        check("R11 reload 1 offset", d, 32'h0000ABCD);
        rd(A_LD0, d);
        check("R11 reload 0 untouched", d, 32'h1234);
        wr(A_LD0, 32'h12345678);
        rd(A_LD0, d);
        check("R11 reload width truncation", d, 32'h5678);
    endtask

    task automatic t_start_all();
        logic [31:0] a, b, a2;
        stop_all();
        wr(A_LD0, 32'd100);
        wr(A_LD1, 32'd100);
        wr(A_CTL0, 32'h41);
        wr(A_CTL1, 32'h41);
        wr(A_CTL1, 32'h101);
        rd(A_CTL0, a);
        check("R10 run set on channel 0", a, 32'h11);
        rd(A_CTL1, a);
        check("R10 run set on channel 1, bit 8 reads 0", a, 32'h11);
        repeat (5) @(negedge clk);
        bus_addr = A_CNT0; #0.5; a = bus_rdata;
        bus_addr = A_CNT1; #0.5; b = bus_rdata;
        check("R10 counters in lockstep", a, b);
        check("R9 counter is live", 32'(a < 32'd100), 32'h1);
        @(negedge clk);
        rd(A_CNT0, a2);
        check("R9 counter steps each clock", a2, a - 32'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_down();
        t_up();
        t_update();
        t_low_cases();
        t_disable();
        t_load_map();
        t_start_all();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

endmodule